// File: doc/BRIEF.md
# Policy-Configurable Register Bank

A bank of 32-bit registers in which every register carries a set of access-policy flags fixed at elaboration. The flags decide what a CPU read returns, what a CPU write does to the stored bits, and whether a read has a side effect. Five flags exist and any of them may be combined on one register: reads-as-zero, writes-ignored, cleared-by-read, write-one-clears and write-one-sets.

Next to the CPU port sits a device port. Hardware logic uses it to overwrite, clear or set bits in any register, whatever that register's flags. The same port exposes every stored value, so hardware sees the control registers it consumes. A CPU access and device updates may reach the same register in one cycle. They merge in a fixed order, so a hardware event raised in that cycle is never lost.

The CPU port takes one access per cycle, with a word index, write data and byte strobes. Read data returns in the following cycle together with a one-cycle valid flag. Reset loads each register with its initial value, which is a parameter.

Top module: `polreg_bank`

## Requirements
- R1: During and after reset, `reg_out` holds `INIT` for every register and `cpu_rvalid` is 0. The default map is: index 0 plain, init 0x12345678; index 1 reads-as-zero, init 0; index 2 writes-ignored, init 0xA5A50001; index 3 cleared-by-read, init 0x000000FF; index 4 write-one-clears, init 0xFFFFFFFF; index 5 write-one-sets, init 0; index 6 writes-ignored plus cleared-by-read, init 0x0F0F0F0F; index 7 write-one-sets plus cleared-by-read, init 0.
- R2: A register with no flags stores CPU write data in the enabled byte lanes, and a CPU read returns its stored value.
- R3: A reads-as-zero register (flag bit 0) returns 0 on every CPU read, and it stores CPU writes like a plain register.
- R4: A writes-ignored register (flag bit 1) is left unchanged by every CPU write. This flag overrides bits 3 and 4.
- R5: A CPU read of a cleared-by-read register (flag bit 2) returns the value it held before the read, and the register is 0 in the next cycle.
- R6: On a CPU write to a write-one-clears register (flag bit 3), each enabled data bit at 1 clears the stored bit, and every other bit keeps its value.
- R7: On a CPU write to a write-one-sets register (flag bit 4), each enabled data bit at 1 sets the stored bit, and every other bit keeps its value.
- R8: Flags combine on one register. Writes-ignored plus cleared-by-read drops writes and clears on read. Write-one-sets plus cleared-by-read sets bits on write and clears on read.
- R9: Bit `cpu_strb[b]` enables byte lane b (bits 8b+7..8b). Under every write flag, bits in disabled lanes are untouched.
- R10: Device updates ignore the flags. `dev_we` replaces the value, then `dev_clr` clears bits, then `dev_set` sets bits. All three act on top of any CPU effect in the same cycle.
- R11: A bit set through `dev_set` is 1 in the next cycle, even if a CPU write-one-clear or a cleared-by-read read hits that register in the same cycle.
- R12: `cpu_rvalid` is 1 exactly in the cycle after a CPU read request, with `cpu_rdata` valid in that cycle. Out-of-range reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads INIT |
| cpu_valid | input | 1 | CPU access request this cycle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | IDX_W | Register index |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_strb | input | DATA_W/8 | Byte-lane enables for writes |
| cpu_rdata | output | DATA_W | Read data, one cycle after the request |
| cpu_rvalid | output | 1 | Read data valid |
| dev_we | input | NUM_REGS | Per-register device full write |
| dev_wdata | input | NUM_REGS x DATA_W | Device write values |
| dev_set | input | NUM_REGS x DATA_W | Device bit-set masks |
| dev_clr | input | NUM_REGS x DATA_W | Device bit-clear masks |
| reg_out | output | NUM_REGS x DATA_W | Stored value of every register |

## Verification
Two functions can collide in one cycle: a CPU access with a side effect (a write-one-clear or a cleared-by-read read) and a device-side set on the same register. The bench starts both in the same cycle. It then judges the register value seen on `reg_out` one cycle later and, for the read case, the data returned. Replacement, clear and set are also driven together on a single register, which shows their order.

// File: rtl/polreg_pkg.sv
package polreg_pkg;

    localparam int POL_W = 5;
    typedef logic [POL_W-1:0] pol_t;

    // flag bit positions
    localparam int PB_WO  = 0;  // reads as zero
    localparam int PB_RO  = 1;  // CPU writes ignored
    localparam int PB_RC  = 2;  // cleared by CPU read
    localparam int PB_W1C = 3;  // write one to clear
    localparam int PB_W1S = 4;  // write one to set

    localparam pol_t POL_NONE = 5'b00000;
    localparam pol_t POL_WO   = 5'b00001;
    localparam pol_t POL_RO   = 5'b00010;
    localparam pol_t POL_RC   = 5'b00100;
    localparam pol_t POL_W1C  = 5'b01000;
    localparam pol_t POL_W1S  = 5'b10000;

endpackage

// File: rtl/polreg_decode.sv
module polreg_decode #(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3
) (
    input  logic                cpu_valid,
    input  logic                cpu_write,
    input  logic [IDX_W-1:0]    cpu_addr,
    output logic [NUM_REGS-1:0] wr_sel,
    output logic [NUM_REGS-1:0] rd_sel
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        logic hit;
        assign hit       = cpu_valid && (cpu_addr == IDX_W'(i));
        assign wr_sel[i] = hit && cpu_write;
        assign rd_sel[i] = hit && !cpu_write;
    end

endmodule

// File: rtl/polreg_cell.sv
module polreg_cell
    import polreg_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter pol_t        POLICY = POL_NONE,
    parameter logic [DATA_W-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] bmask,
    input  logic              dev_we,
    input  logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_set,
    input  logic [DATA_W-1:0] dev_clr,
    output logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] rd_view
);

    localparam bit IS_WO  = POLICY[PB_WO];
    localparam bit IS_RO  = POLICY[PB_RO];
    localparam bit IS_RC  = POLICY[PB_RC];
    localparam bit IS_W1C = POLICY[PB_W1C];
    localparam bit IS_W1S = POLICY[PB_W1S];

    logic [DATA_W-1:0] value_d, value_q;
    logic [DATA_W-1:0] cpu_val;
    logic [DATA_W-1:0] hit_bits;

    always_comb begin
        hit_bits = wdata & bmask;
        cpu_val  = value_q;
        // CPU write effect, chosen by the policy flags
        if (wr_en && !IS_RO) begin
            if (IS_W1C || IS_W1S) begin
                if (IS_W1C) cpu_val = cpu_val & ~hit_bits;
                if (IS_W1S) cpu_val = cpu_val | hit_bits;
            end else begin
                cpu_val = (value_q & ~bmask) | hit_bits;
            end
        end
        // read side effect
        if (rd_en && IS_RC) cpu_val = '0;
        // device side: replace, then clear, then set (set wins)
        value_d = dev_we ? dev_wdata : cpu_val;
        value_d = value_d & ~dev_clr;
        value_d = value_d | dev_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value_q <= INIT;
        else        value_q <= value_d;
    end

    assign value   = value_q;
    assign rd_view = IS_WO ? '0 : value_q;

endmodule

// File: rtl/polreg_rdmux.sv
module polreg_rdmux #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32
) (
    input  logic [NUM_REGS-1:0]             rd_sel,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] views,
    output logic [DATA_W-1:0]               rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            rdata = rdata | (views[i] & {DATA_W{rd_sel[i]}});
        end
    end

endmodule

// File: rtl/polreg_bank.sv
module polreg_bank
    import polreg_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter pol_t [NUM_REGS-1:0] POLICY = {
        pol_t'(POL_W1S | POL_RC), pol_t'(POL_RO | POL_RC), POL_W1S, POL_W1C,
        POL_RC, POL_RO, POL_WO, POL_NONE},
    parameter logic [NUM_REGS-1:0][DATA_W-1:0] INIT = {
        32'h0000_0000, 32'h0F0F_0F0F, 32'h0000_0000, 32'hFFFF_FFFF,
        32'h0000_00FF, 32'hA5A5_0001, 32'h0000_0000, 32'h1234_5678},
    localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cpu_valid,
    input  logic                             cpu_write,
    input  logic [IDX_W-1:0]                 cpu_addr,
    input  logic [DATA_W-1:0]                cpu_wdata,
    input  logic [STRB_W-1:0]                cpu_strb,
    output logic [DATA_W-1:0]                cpu_rdata,
    output logic                             cpu_rvalid,
    input  logic [NUM_REGS-1:0]              dev_we,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  dev_wdata,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  dev_set,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  dev_clr,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  reg_out
);

    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [NUM_REGS-1:0]             wr_sel, rd_sel;
    logic [NUM_REGS-1:0][DATA_W-1:0] views;
    logic [DATA_W-1:0]               mux_data;
    logic [DATA_W-1:0]               bmask;

    for (genvar b = 0; b < STRB_W; b++) begin : g_lane
        assign bmask[b*8 +: 8] = {8{cpu_strb[b]}};
    end

    polreg_decode #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .cpu_valid (cpu_valid),
        .cpu_write (cpu_write),
        .cpu_addr  (cpu_addr),
        .wr_sel    (wr_sel),
        .rd_sel    (rd_sel)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        polreg_cell #(
            .DATA_W (DATA_W),
            .POLICY (POLICY[i]),
            .INIT   (INIT[i])
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_sel[i]),
            .rd_en     (rd_sel[i]),
            .wdata     (cpu_wdata),
            .bmask     (bmask),
            .dev_we    (dev_we[i]),
            .dev_wdata (dev_wdata[i]),
            .dev_set   (dev_set[i]),
            .dev_clr   (dev_clr[i]),
            .value     (reg_out[i]),
            .rd_view   (views[i])
        );
    end

    polreg_rdmux #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_rdmux (
        .rd_sel (rd_sel),
        .views  (views),
        .rdata  (mux_data)
    );

    always_comb begin
        rsp_d        = rsp_q;
        rsp_d.rvalid = cpu_valid && !cpu_write;
        if (cpu_valid && !cpu_write) rsp_d.rdata = mux_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign cpu_rdata  = rsp_q.rdata;
    assign cpu_rvalid = rsp_q.rvalid;

endmodule

// File: rtl/polreg_bank_chk.sv
module polreg_bank_chk
    import polreg_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 3,
    parameter pol_t [NUM_REGS-1:0] POLICY = '0
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             cpu_valid,
    input logic                             cpu_write,
    input logic [IDX_W-1:0]                 cpu_addr,
    input logic [DATA_W-1:0]                cpu_rdata,
    input logic                             cpu_rvalid,
    input logic [NUM_REGS-1:0]              dev_we,
    input logic [NUM_REGS-1:0][DATA_W-1:0]  dev_set,
    input logic [NUM_REGS-1:0][DATA_W-1:0]  dev_clr,
    input logic [NUM_REGS-1:0][DATA_W-1:0]  reg_out
);

    // R12
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !cpu_write) |=> cpu_rvalid);

    // R12
    rvalid_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_valid && !cpu_write) |=> !cpu_rvalid);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
        // R11
        set_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_set[i] != '0) |=> ((reg_out[i] & $past(dev_set[i])) == $past(dev_set[i])));

        if (POLICY[i][PB_RO] && !POLICY[i][PB_RC]) begin : g_ro
            // R4
            ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!dev_we[i] && dev_set[i] == '0 && dev_clr[i] == '0) |=> $stable(reg_out[i]));
        end

        if (POLICY[i][PB_WO]) begin : g_wo
            // R3
            wo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cpu_valid && !cpu_write && cpu_addr == IDX_W'(i)) |=> (cpu_rdata == '0));
        end

        if (POLICY[i][PB_RC]) begin : g_rc
            // R5
            rc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cpu_valid && !cpu_write && cpu_addr == IDX_W'(i) && !dev_we[i] && dev_set[i] == '0)
                |=> (reg_out[i] == '0));
        end
    end

endmodule

bind polreg_bank polreg_bank_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .POLICY   (POLICY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_write  (cpu_write),
    .cpu_addr   (cpu_addr),
    .cpu_rdata  (cpu_rdata),
    .cpu_rvalid (cpu_rvalid),
    .dev_we     (dev_we),
    .dev_set    (dev_set),
    .dev_clr    (dev_clr),
    .reg_out    (reg_out)
);

// File: tb/polreg_bank_tb.sv
`timescale 1ns/1ps
module polreg_bank_tb;

    localparam int N  = 8;
    localparam int DW = 32;
    localparam int NV = 20;

    logic clk = 1'b0;
    logic rst_n;
    logic cpu_valid, cpu_write;
    logic [2:0] cpu_addr;
    logic [DW-1:0] cpu_wdata;
    logic [3:0] cpu_strb;
    logic [DW-1:0] cpu_rdata;
    logic cpu_rvalid;
    logic [N-1:0] dev_we;
    logic [N-1:0][DW-1:0] dev_wdata, dev_set, dev_clr, reg_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    polreg_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_strb(cpu_strb),
        .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .dev_we(dev_we), .dev_wdata(dev_wdata), .dev_set(dev_set), .dev_clr(dev_clr),
        .reg_out(reg_out)
    );

    localparam logic [DW-1:0] EXP_INIT [N] = '{
        32'h1234_5678, 32'h0, 32'hA5A5_0001, 32'h0000_00FF,
        32'hFFFF_FFFF, 32'h0, 32'h0F0F_0F0F, 32'h0};

    // {write, index, data, strobes, expected read data, expected register}
    localparam logic [103:0] VEC [NV] = '{
        {1'b0, 3'd0, 32'h0,         4'h0, 32'h1234_5678, 32'h1234_5678},
        {1'b1, 3'd0, 32'hAABB_CCDD, 4'h5, 32'h0,         32'h12BB_56DD}, // R9 lanes
        {1'b0, 3'd0, 32'h0,         4'h0, 32'h12BB_56DD, 32'h12BB_56DD},
        {1'b1, 3'd1, 32'hDEAD_BEEF, 4'hF, 32'h0,         32'hDEAD_BEEF},
        {1'b0, 3'd1, 32'h0,         4'h0, 32'h0,         32'hDEAD_BEEF},
        {1'b1, 3'd2, 32'hFFFF_FFFF, 4'hF, 32'h0,         32'hA5A5_0001},
        {1'b0, 3'd2, 32'h0,         4'h0, 32'hA5A5_0001, 32'hA5A5_0001},
        {1'b0, 3'd3, 32'h0,         4'h0, 32'h0000_00FF, 32'h0},
        {1'b0, 3'd3, 32'h0,         4'h0, 32'h0,         32'h0},
        {1'b1, 3'd4, 32'h0000_00F0, 4'h1, 32'h0,         32'hFFFF_FF0F},
        {1'b1, 3'd4, 32'hF000_0000, 4'h7, 32'h0,         32'hFFFF_FF0F}, // R9 W1C
        {1'b1, 3'd4, 32'h0F00_0000, 4'h8, 32'h0,         32'hF0FF_FF0F},
        {1'b1, 3'd5, 32'h0000_0011, 4'hF, 32'h0,         32'h0000_0011},
        {1'b1, 3'd5, 32'h0000_0100, 4'hF, 32'h0,         32'h0000_0111},
        {1'b1, 3'd5, 32'hFF00_0000, 4'h3, 32'h0,         32'h0000_0111}, // R9 W1S
        {1'b1, 3'd6, 32'h0,         4'hF, 32'h0,         32'h0F0F_0F0F},
        {1'b0, 3'd6, 32'h0,         4'h0, 32'h0F0F_0F0F, 32'h0},
        {1'b1, 3'd7, 32'h0000_0003, 4'hF, 32'h0,         32'h0000_0003},
        {1'b0, 3'd7, 32'h0,         4'h0, 32'h0000_0003, 32'h0},
        {1'b0, 3'd5, 32'h0,         4'h0, 32'h0000_0111, 32'h0000_0111}
    };

    function automatic string tag_of(input logic [2:0] idx);
        case (idx)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic dev_idle();
        dev_we = '0; dev_wdata = '0; dev_set = '0; dev_clr = '0;
    endtask

    // call at a falling edge; returns at the next falling edge with valid low
    task automatic cpu_op(input logic wr, input logic [2:0] idx,
                          input logic [DW-1:0] d, input logic [3:0] s);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = idx; cpu_wdata = d; cpu_strb = s;
        @(negedge clk);
        cpu_valid = 1'b0; cpu_write = 1'b0;
        dev_idle();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        cpu_valid = 1'b0; cpu_write = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_strb = '0;
        dev_idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < N; i++) chk("R1 init", reg_out[i], EXP_INIT[i]);
        chk("R1 rvalid", 32'(cpu_rvalid), 32'h0);

        // policy table
        for (int k = 0; k < NV; k++) begin
            logic [103:0] v;
            v = VEC[k];
            cpu_op(v[103], v[102:100], v[99:68], v[67:64]);
            chk(tag_of(v[102:100]), reg_out[v[102:100]], v[31:0]);
            if (!v[103]) begin
                chk(tag_of(v[102:100]), cpu_rdata, v[63:32]);
                chk("R12 rvalid read", 32'(cpu_rvalid), 32'h1);
            end else begin
                chk("R12 rvalid write", 32'(cpu_rvalid), 32'h0);
            end
        end

        // R10 device port ignores flags; replace, clear, set order
        dev_we[2] = 1'b1; dev_wdata[2] = 32'h1111_2222;
        dev_we[0] = 1'b1; dev_wdata[0] = 32'hFFFF_0000;
        dev_clr[0] = 32'h00FF_0000; dev_set[0] = 32'h0000_0001;
        dev_clr[5] = 32'h0000_0001;
        @(negedge clk);
        dev_idle();
        chk("R10 ro bypass", reg_out[2], 32'h1111_2222);
        chk("R10 order", reg_out[0], 32'hFF00_0001);
        chk("R10 clear", reg_out[5], 32'h0000_0110);

        // R11 device set against CPU write-one-clear in the same cycle
        dev_set[4] = 32'h0000_0005;
        cpu_op(1'b1, 3'd4, 32'hFFFF_FFFF, 4'hF);
        chk("R11 w1c", reg_out[4], 32'h0000_0005);

        // R11 device set against clear-by-read in the same cycle
        dev_set[3] = 32'h0000_0080;
        cpu_op(1'b0, 3'd3, 32'h0, 4'h0);
        chk("R11 rc data", cpu_rdata, 32'h0);
        chk("R11 rc keep", reg_out[3], 32'h0000_0080);
        cpu_op(1'b0, 3'd3, 32'h0, 4'h0);
        chk("R5 rc data", cpu_rdata, 32'h0000_0080);
        chk("R5 rc clear", reg_out[3], 32'h0);

        // R12 valid pulse lasts one cycle
        cpu_op(1'b0, 3'd0, 32'h0, 4'h0);
        chk("R12 pulse", 32'(cpu_rvalid), 32'h1);
        @(negedge clk);
        chk("R12 idle", 32'(cpu_rvalid), 32'h0);

        // R1 reset in mid-run restores initial values
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rerst 0", reg_out[0], 32'h1234_5678);
        chk("R1 rerst 2", reg_out[2], 32'hA5A5_0001);
        chk("R1 rerst 4", reg_out[4], 32'hFFFF_FFFF);
        chk("R1 rerst 5", reg_out[5], 32'h0);

        finish_run();
    end

endmodule